// File: doc/BRIEF.md
# Windowed Partial-Match Detector CAM

This block is a content-addressable memory of detector words. Each entry holds a data word, a don't-care mask of the same width and a valid bit. A search compares a key against every entry at once. A hit does not need the whole word to agree. It needs only a contiguous run of `c` bit positions, taken from the low `l` positions of the key. Both `c` and `l` are supplied with each search.

The block does not compare every possible run in one step. It sweeps a window of `c` ones across the active string, moving one position per clock. Position `k` covers bits `k` to `k+c-1`, and a search of window length `c` over string length `l` therefore lasts `l-c+1` compare cycles. During each cycle all entries are compared in parallel under the current window, further narrowed by each entry's own mask.

The found flag collects hits over the whole sweep. The reported address is the lowest entry that matched in any window. A one-cycle done pulse ends the search. Detector words are loaded through a simple write port. That port is stalled while a search is running, so the table cannot change under a sweep.

Top module: `pm_window_cam`

## Requirements
- R1: After reset `busy`, `done`, `found` and `match_addr` are 0, `wr_ready` is 1, and every entry is invalid.
- R2: A write with `wr_en` high and `wr_ready` high stores `wr_data` and `wr_dc_mask` at `wr_addr` and marks the entry valid. An entry that has never been written never matches.
- R3: A mask bit of 1 marks that bit position of the entry as don't-care, and that position is left out of the comparison. A mask bit of 0 means the position is compared.
- R4: In window step `k`, counting from 0, only key bits `k` to `k+c-1` are compared. A difference outside that run does not prevent a hit in that step.
- R5: A search accepted at a clock edge keeps `busy` high for exactly `l-c+1` cycles. `done` is high in the cycle after the last compare cycle. `found` is 1 when any valid entry agrees on all compared positions of some window.
- R6: When several entries match, in the same window or in different windows, `match_addr` is the lowest matching entry address.
- R7: `found` and `match_addr` are cleared when a search is accepted. After `done` they hold their result until the next accepted search. With no hit, both read 0.
- R8: A start request that arrives while `busy` is high is ignored. The running search keeps its key, its length and its result.
- R9: `wr_ready` is low while a search runs, and a write request during that time does not change the table.
- R10: String length 0 is treated as 1, and a length above the word width is treated as the word width. Window length 0 is treated as 1, and a window longer than the clamped string is treated as equal to it. `done` still arrives after `l-c+1` cycles, using the clamped values.
- R11: `done` is a single-cycle pulse, never high together with `busy`, and it follows every fall of `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | 7 | Entry address to write |
| wr_data | input | 32 | Detector word |
| wr_dc_mask | input | 32 | Don't-care mask, 1 = position ignored |
| wr_ready | output | 1 | Write accepted in this cycle when high |
| srch_start | input | 1 | Search request, taken when idle |
| srch_key | input | 32 | Search string, active in its low `l` bits |
| cfg_win | input | 6 | Window length `c` |
| cfg_len | input | 6 | Active string length `l` |
| busy | output | 1 | Window sweep in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| found | output | 1 | A hit occurred during the last search |
| match_addr | output | 7 | Lowest matching entry address |

## Verification
The bench builds the block with its default 32-bit words and 128 entries, so the full sweep range is reachable, from one compare cycle (`c = l`) up to 32 cycles (`c = 1`, `l = 32`). All 128 entries are filled with sparse-care masks. Entries at both ends of the address range then compete in random searches, which exercises the lowest-address rule across different window steps. The 6-bit configuration inputs can carry lengths above 32 and zero, so the clamping paths are driven directly.

// File: rtl/wcam_pkg.sv
package wcam_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } wcam_state_e;

    function automatic int unsigned wcam_len_w(input int unsigned data_w);
        return $clog2(data_w) + 1;
    endfunction

endpackage

// File: rtl/wcam_store.sv
module wcam_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 128,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] dc_mask,
    output logic [DATA_W-1:0] ent_data [DEPTH],
    output logic [DATA_W-1:0] ent_dc   [DEPTH],
    output logic [DEPTH-1:0]  ent_vld
);

    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DATA_W-1:0] dc_q   [DEPTH];
    logic [DEPTH-1:0]  vld_d, vld_q;

    always_comb begin
        vld_d = vld_q;
        if (we) begin
            vld_d[addr] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q <= vld_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            data_q[addr] <= data;
            dc_q[addr]   <= dc_mask;
        end
    end

    assign ent_data = data_q;
    assign ent_dc   = dc_q;
    assign ent_vld  = vld_q;

endmodule

// File: rtl/wcam_win_mask.sv
module wcam_win_mask #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned LW    = $clog2(DATA_W) + 1
) (
    input  logic [LW-1:0]     win_len,
    input  logic [LW-1:0]     step,
    output logic [DATA_W-1:0] mask
);

    logic [DATA_W:0] ones_w;

    always_comb begin
        ones_w = ((DATA_W+1)'(1) << win_len) - (DATA_W+1)'(1);
        mask   = ones_w[DATA_W-1:0] << step;
    end

endmodule

// File: rtl/wcam_cmp_array.sv
module wcam_cmp_array #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 128
) (
    input  logic [DATA_W-1:0] key,
    input  logic [DATA_W-1:0] win_mask,
    input  logic [DATA_W-1:0] ent_data [DEPTH],
    input  logic [DATA_W-1:0] ent_dc   [DEPTH],
    input  logic [DEPTH-1:0]  ent_vld,
    output logic [DEPTH-1:0]  hit
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [DATA_W-1:0] diff;
        assign diff   = (key ^ ent_data[g]) & ~ent_dc[g] & win_mask;
        assign hit[g] = ent_vld[g] && (diff == '0);
    end

endmodule

// File: rtl/wcam_lowest.sv
module wcam_lowest #(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] hit,
    output logic             any,
    output logic [AW-1:0]    idx
);

    always_comb begin
        any = |hit;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit[i]) begin
                idx = AW'(i);
            end
        end
    end

endmodule

// File: rtl/pm_window_cam.sv
module pm_window_cam
    import wcam_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 128,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned LW    = $clog2(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_dc_mask,
    output logic              wr_ready,
    input  logic              srch_start,
    input  logic [DATA_W-1:0] srch_key,
    input  logic [LW-1:0]     cfg_win,
    input  logic [LW-1:0]     cfg_len,
    output logic              busy,
    output logic              done,
    output logic              found,
    output logic [AW-1:0]     match_addr
);

    typedef struct packed {
        wcam_state_e       state;
        logic [DATA_W-1:0] key;
        logic [LW-1:0]     win;
        logic [LW-1:0]     step;
        logic [LW-1:0]     last;
        logic              found;
        logic [AW-1:0]     addr;
        logic              done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        state: ST_IDLE, key: '0, win: '0, step: '0, last: '0,
        found: 1'b0, addr: '0, done: 1'b0
    };

    ctl_t ctl_d, ctl_q;

    logic [DATA_W-1:0] ent_data [DEPTH];
    logic [DATA_W-1:0] ent_dc   [DEPTH];
    logic [DEPTH-1:0]  ent_vld;
    logic [DATA_W-1:0] win_mask;
    logic [DEPTH-1:0]  hit;
    logic              hit_any;
    logic [AW-1:0]     hit_idx;
    logic              store_we;
    logic [LW-1:0]     len_eff;
    logic [LW-1:0]     win_eff;

    assign store_we = wr_en && (ctl_q.state == ST_IDLE);

    wcam_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (store_we),
        .addr     (wr_addr),
        .data     (wr_data),
        .dc_mask  (wr_dc_mask),
        .ent_data (ent_data),
        .ent_dc   (ent_dc),
        .ent_vld  (ent_vld)
    );

    wcam_win_mask #(.DATA_W(DATA_W)) u_win (
        .win_len (ctl_q.win),
        .step    (ctl_q.step),
        .mask    (win_mask)
    );

    wcam_cmp_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_cmp (
        .key      (ctl_q.key),
        .win_mask (win_mask),
        .ent_data (ent_data),
        .ent_dc   (ent_dc),
        .ent_vld  (ent_vld),
        .hit      (hit)
    );

    wcam_lowest #(.DEPTH(DEPTH)) u_low (
        .hit (hit),
        .any (hit_any),
        .idx (hit_idx)
    );

    // Range clamping of the runtime lengths
    always_comb begin
        if (cfg_len == '0) begin
            len_eff = LW'(1);
        end else if (cfg_len > LW'(DATA_W)) begin
            len_eff = LW'(DATA_W);
        end else begin
            len_eff = cfg_len;
        end
        if (cfg_win == '0) begin
            win_eff = LW'(1);
        end else if (cfg_win > len_eff) begin
            win_eff = len_eff;
        end else begin
            win_eff = cfg_win;
        end
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (srch_start) begin
                    ctl_d.state = ST_SCAN;
                    ctl_d.key   = srch_key;
                    ctl_d.win   = win_eff;
                    ctl_d.step  = '0;
                    ctl_d.last  = len_eff - win_eff;
                    ctl_d.found = 1'b0;
                    ctl_d.addr  = '0;
                end
            end
            ST_SCAN: begin
                if (hit_any && (!ctl_q.found || (hit_idx < ctl_q.addr))) begin
                    ctl_d.found = 1'b1;
                    ctl_d.addr  = hit_idx;
                end
                if (ctl_q.step == ctl_q.last) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.done  = 1'b1;
                end else begin
                    ctl_d.step = ctl_q.step + LW'(1);
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy       = (ctl_q.state == ST_SCAN);
    assign wr_ready   = (ctl_q.state == ST_IDLE);
    assign done       = ctl_q.done;
    assign found      = ctl_q.found;
    assign match_addr = ctl_q.addr;

endmodule

// File: rtl/wcam_chk.sv
module wcam_chk #(
    parameter int unsigned AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          srch_start,
    input logic          busy,
    input logic          done,
    input logic          found,
    input logic [AW-1:0] match_addr,
    input logic          wr_ready
);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R11
    fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_start && !busy) |=> (busy && !found && match_addr == '0));

    // R7
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !srch_start) |=> ($stable(found) && $stable(match_addr)));

    // R9
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_ready);

endmodule

bind pm_window_cam wcam_chk #(.AW(AW)) u_wcam_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .srch_start (srch_start),
    .busy       (busy),
    .done       (done),
    .found      (found),
    .match_addr (match_addr),
    .wr_ready   (wr_ready)
);

// File: tb/pm_window_cam_bench.sv
module pm_window_cam_bench;

    localparam int DW = 32;
    localparam int DP = 128;
    localparam int AW = 7;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] wr_dc_mask = '0;
    logic          wr_ready;
    logic          srch_start = 1'b0;
    logic [DW-1:0] srch_key = '0;
    logic [LW-1:0] cfg_win = '0;
    logic [LW-1:0] cfg_len = '0;
    logic          busy, done, found;
    logic [AW-1:0] match_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [DW-1:0] ref_data [DP];
    logic [DW-1:0] ref_dc   [DP];
    bit            ref_vld  [DP];

    always #4 clk = ~clk;

    pm_window_cam u_pm_window_cam (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_dc_mask(wr_dc_mask), .wr_ready(wr_ready),
        .srch_start(srch_start), .srch_key(srch_key), .cfg_win(cfg_win),
        .cfg_len(cfg_len), .busy(busy), .done(done), .found(found),
        .match_addr(match_addr)
    );

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    function automatic void clamp(input int c_in, input int l_in, output int c, output int l);
        l = (l_in == 0) ? 1 : ((l_in > DW) ? DW : l_in);
        c = (c_in == 0) ? 1 : ((c_in > l) ? l : c_in);
    endfunction

    function automatic void ref_search(input logic [DW-1:0] key, input int c_in, input int l_in,
                                       output bit f, output int a, output int n);
        int c, l;
        logic [63:0] wm;
        clamp(c_in, l_in, c, l);
        n = l - c + 1;
        f = 0;
        a = 0;
        for (int k = 0; k <= l - c; k++) begin
            wm = ((64'd1 << c) - 64'd1) << k;
            for (int e = 0; e < DP; e++) begin
                if (ref_vld[e] && (((key ^ ref_data[e]) & ~ref_dc[e] & wm[DW-1:0]) == '0)
                    && (!f || e < a)) begin
                    f = 1;
                    a = e;
                end
            end
        end
    endfunction

    task automatic write_ent(input int a, input logic [DW-1:0] d, input logic [DW-1:0] m);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = AW'(a);
        wr_data = d;
        wr_dc_mask = m;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        ref_data[a] = d;
        ref_dc[a] = m;
        ref_vld[a] = 1;
    endtask

    task automatic search_dut(input logic [DW-1:0] key, input int c, input int l,
                              output bit f, output int a, output int n);
        @(negedge clk);
        srch_start = 1'b1;
        srch_key = key;
        cfg_win = LW'(c);
        cfg_len = LW'(l);
        @(negedge clk);
        srch_start = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 100);
        f = found;
        a = int'(match_addr);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        bit f, ef;
        int a, ea, n, en;
        logic [DW-1:0] care10;
        for (int i = 0; i < DP; i++) begin
            ref_vld[i] = 0;
            ref_data[i] = '0;
            ref_dc[i] = '0;
        end
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "found", found, 0);
        chk("R1", "match_addr", match_addr, 0);
        chk("R1", "wr_ready", wr_ready, 1);
        // R1 R2 empty table never matches, even with all-zero key
        search_dut(32'h0, 32, 32, f, a, n);
        chk("R2", "found on empty table", f, 0);
        chk("R5", "cycles c=l=32", n, 1);

        care10 = ~32'h3FF;
        write_ent(10, 32'h0000_03A5, care10);
        search_dut(32'h3A5, 10, 10, f, a, n);
        chk("R5", "found exact", f, 1);
        chk("R5", "addr exact", a, 10);
        // R4 difference at bit 9 lies outside window 0 (bits 0..6)
        search_dut(32'h3A5 ^ 32'h200, 7, 10, f, a, n);
        chk("R4", "found outer diff", f, 1);
        chk("R4", "addr outer diff", a, 10);
        chk("R5", "cycles l=10 c=7", n, 4);
        // R4 difference at bit 3 lies inside every window
        search_dut(32'h3A5 ^ 32'h8, 7, 10, f, a, n);
        chk("R4", "found inner diff", f, 0);
        chk("R7", "addr with no hit", a, 0);
        // R3 don't-care on bit 3
        write_ent(4, 32'h0000_03A5, care10 | 32'h8);
        search_dut(32'h3A5 ^ 32'h8, 10, 10, f, a, n);
        chk("R3", "found with dont-care", f, 1);
        chk("R3", "addr with dont-care", a, 4);
        // R6 two entries match, lower wins
        search_dut(32'h3A5, 10, 10, f, a, n);
        chk("R6", "lowest of two", a, 4);

        // R9 write attempt during a 32-cycle search
        @(negedge clk);
        srch_start = 1'b1;
        srch_key = 32'hFFFF_0000;
        cfg_win = 6'd1;
        cfg_len = 6'd32;
        @(negedge clk);
        srch_start = 1'b0;
        chk("R9", "wr_ready while busy", wr_ready, 0);
        wr_en = 1'b1;
        wr_addr = '0;
        wr_data = 32'h1234_5678;
        wr_dc_mask = '0;
        repeat (2) @(negedge clk);
        wr_en = 1'b0;
        // R8 start pulse mid-search is ignored
        srch_start = 1'b1;
        srch_key = 32'h3A5;
        cfg_win = 6'd10;
        cfg_len = 6'd10;
        @(negedge clk);
        srch_start = 1'b0;
        n = 3;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk("R8", "cycles unchanged by second start", n, 32);
        ref_search(32'hFFFF_0000, 1, 32, ef, ea, en);
        chk("R8", "found of first key", found, ef);
        chk("R8", "addr of first key", match_addr, ea);
        // R7 result held while idle
        repeat (3) @(negedge clk);
        chk("R7", "found held", found, ef);
        search_dut(32'h1234_5678, 32, 32, f, a, n);
        chk("R9", "blocked write left no entry", f, 0);
        write_ent(0, 32'h1234_5678, 32'h0);
        search_dut(32'h1234_5678, 32, 32, f, a, n);
        chk("R2", "idle write takes effect", f, 1);
        chk("R2", "idle write addr", a, 0);

        // R10 clamping
        search_dut(32'h0, 50, 40, f, a, n);
        chk("R10", "cycles l>32 c>l", n, 1);
        search_dut(32'h0, 0, 0, f, a, n);
        chk("R10", "cycles l=0 c=0", n, 1);
        search_dut(32'h0, 9, 5, f, a, n);
        chk("R10", "cycles c>l", n, 1);
        search_dut(32'h0, 0, 20, f, a, n);
        chk("R10", "cycles c=0 l=20", n, 20);

        // random fill and searches
        for (int i = 0; i < DP; i++) begin
            write_ent(i, $urandom, $urandom | $urandom | $urandom);
        end
        for (int t = 0; t < 90; t++) begin
            int e, c, l;
            logic [DW-1:0] key;
            e = int'($urandom % DP);
            key = ref_data[e] ^ ($urandom & $urandom & $urandom);
            if ($urandom % 8 == 0) begin
                l = int'($urandom % 64);
                c = int'($urandom % 64);
            end else begin
                l = 1 + int'($urandom % 32);
                c = 1 + int'($urandom % l);
            end
            ref_search(key, c, l, ef, ea, en);
            search_dut(key, c, l, f, a, n);
            chk("R5", "random found", f, ef);
            chk("R6", "random addr", a, ea);
            chk("R10", "random cycles", n, en);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule